// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Buffer

This block keeps a calendar clock in packed BCD: seconds, minutes, hours, date, month, two-digit year, a century byte and a day-of-week counter. It advances by one second on each cycle in which the 1 Hz enable is high. It handles 12-hour and 24-hour formats, months of 28 to 31 days, and a leap rule based on the two-digit year.

A host never touches the live counters directly. To read, it pulses a capture strobe, which copies the running time into a read latch that drives every output; the live clock keeps counting. To write, it pulses a load strobe, which copies the running time into a shadow buffer. The buffer then keeps counting with each tick while byte-wide field writes replace individual fields. A commit strobe moves the whole buffer into the live counters in one cycle. An abort strobe throws the buffer away.

After reset, which stands for a total power loss, the clock stays frozen and the clock-fail flag stays high. Both clear on the first commit that carries at least one written byte.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes each count 00..59 in BCD. A field wraps to 00 only when it is at 59, and that wrap carries into the next field. A tick that does not wrap the seconds leaves the minutes unchanged.
- R2: Hour byte encoding: bit 7 set selects 24-hour mode. In that mode bits 5:0 hold BCD hours 00..23, and the step from 23 to 00 advances the day.
- R3: With hour bit 7 clear, bits 4:0 hold BCD 01..12 and bit 5 set means PM. The step from 11 to 12 toggles bit 5. The step from 12 to 01 keeps bit 5. Only the step from 11 PM to 12 AM advances the day.
- R4: The date rolls to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. February ends on day 29 when the two-digit year value is a multiple of 4 (00 included) and on day 28 otherwise.
- R5: After month 12 the month returns to 01 and the year increments. After year 99 the year returns to 00 and the century byte becomes 8'h20, whether it held 8'h19 or 8'h20.
- R6: The day-of-week counter (3 bits) advances 0,1,..,6,0 with every day advance.
- R7: A capture pulse copies the live time into the read latch that drives all field outputs. Without a capture pulse the outputs hold while the live time keeps counting.
- R8: A load pulse copies the live time into the shadow buffer and opens it. If a tick falls in the load cycle, the buffer takes the ticked time. An open buffer advances on every counting tick. A field write replaces only the addressed field. Field index encoding: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day-of-week (data bits 2:0), 7 century.
- R9: A commit pulse, while the buffer is open and holds at least one written byte, loads the buffer into the live time in one cycle. A tick in the commit cycle is dropped, so counting resumes on the next tick.
- R10: An abort pulse closes the buffer and leaves the live time unchanged. So does a commit pulse with no written byte. Field writes while no buffer is open are ignored. Abort takes priority over commit, and commit over load.
- R11: Reset sets the time to century 20, year 00, month 01, date 01, 12:00:00 AM in 12-hour mode, day-of-week 0, and raises the clock-fail flag. While the flag is high, neither the live time nor an open buffer advances. The first effective commit clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (total power loss) |
| tick_i | input | 1 | One-second advance enable |
| rd_capture_i | input | 1 | Copy live time into the read latch |
| wr_load_i | input | 1 | Copy live time into the shadow buffer and open it |
| wr_byte_i | input | 1 | Write one field of the open buffer |
| wr_idx_i | input | 3 | Field index of the write |
| wr_data_i | input | 8 | Field value of the write |
| wr_commit_i | input | 1 | Apply the buffer to the live time |
| wr_abort_i | input | 1 | Discard the buffer |
| rd_sec_o | output | 8 | Latched seconds, BCD |
| rd_min_o | output | 8 | Latched minutes, BCD |
| rd_hour_o | output | 8 | Latched hour byte (mode bit 7, PM bit 5) |
| rd_date_o | output | 8 | Latched date, BCD |
| rd_month_o | output | 8 | Latched month, BCD |
| rd_year_o | output | 8 | Latched year, BCD |
| rd_cent_o | output | 8 | Latched century, BCD |
| rd_dow_o | output | 3 | Latched day of week |
| clk_fail_o | output | 1 | Clock-fail flag |

## Verification
Directed end-of-period times, each followed by one tick, separate the carry chains. The cases are 23:59:59 on the last day of each short month, February in leap and common years, and December 31 of year 99 under both century values. They also cover both 12-hour noon and midnight crossings and the 12-to-01 step in each half of the day. Timing cases separate buffer behaviours that a plain preset could not: ticks while the buffer is open, a tick in the load cycle, a tick in the commit cycle, abort, stray writes and a commit with no byte written. Random valid start times, biased toward the end of a day and month, run up to 3000 ticks each against a model that counts in binary. These runs expose carry mistakes that the directed corners do not line up.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W     = 8;
  localparam int DOW_W      = 3;
  localparam int NUM_FIELDS = 8;
  localparam int IDX_W      = $clog2(NUM_FIELDS);

  typedef enum logic [IDX_W-1:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_DATE  = 3'd3,
    F_MONTH = 3'd4,
    F_YEAR  = 3'd5,
    F_DOW   = 3'd6,
    F_CENT  = 3'd7
  } field_e;

  typedef struct packed {
    logic [BYTE_W-1:0] cent;
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] month;
    logic [BYTE_W-1:0] date;
    logic [DOW_W-1:0]  dow;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                 date: 8'h01, dow: 3'd0, hour: 8'h12,
                                 min: 8'h00, sec: 8'h00};
endpackage

// File: rtl/rtc_time_next.sv
module rtc_time_next
  import rtc_cal_pkg::*;
(
  input  cal_t cur_i,
  output cal_t nxt_o
);
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  logic              leap;
  logic [BYTE_W-1:0] last_day;
  logic              c_min, c_hr, c_day;
  cal_t              n;

  // BCD year divisible by 4: even tens need units 0/4/8, odd tens need 2/6
  assign leap = (cur_i.year[1:0] == {cur_i.year[4], 1'b0});

  always_comb begin
    case (cur_i.month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    n     = cur_i;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    if (cur_i.sec == 8'h59) begin
      n.sec = 8'h00;
      c_min = 1'b1;
    end else begin
      n.sec = bcd_inc(cur_i.sec);
    end
    if (c_min) begin
      if (cur_i.min == 8'h59) begin
        n.min = 8'h00;
        c_hr  = 1'b1;
      end else begin
        n.min = bcd_inc(cur_i.min);
      end
    end
    if (c_hr) begin
      if (cur_i.hour[7]) begin
        if (cur_i.hour[5:0] == 6'h23) begin
          n.hour = 8'h80;
          c_day  = 1'b1;
        end else if (cur_i.hour[3:0] == 4'd9) begin
          n.hour = {2'b10, cur_i.hour[5:4] + 2'd1, 4'd0};
        end else begin
          n.hour = {2'b10, cur_i.hour[5:4], cur_i.hour[3:0] + 4'd1};
        end
      end else begin
        if (cur_i.hour[4:0] == 5'h12) begin
          n.hour = {2'b00, cur_i.hour[5], 5'h01};
        end else if (cur_i.hour[4:0] == 5'h11) begin
          n.hour = {2'b00, ~cur_i.hour[5], 5'h12};
          c_day  = cur_i.hour[5];
        end else if (cur_i.hour[3:0] == 4'd9) begin
          n.hour = {2'b00, cur_i.hour[5], 5'h10};
        end else begin
          n.hour = {2'b00, cur_i.hour[5], cur_i.hour[4], cur_i.hour[3:0] + 4'd1};
        end
      end
    end
    if (c_day) begin
      n.dow = (cur_i.dow == 3'd6) ? 3'd0 : cur_i.dow + 3'd1;
      if (cur_i.date == last_day) begin
        n.date = 8'h01;
        if (cur_i.month == 8'h12) begin
          n.month = 8'h01;
          if (cur_i.year == 8'h99) begin
            n.year = 8'h00;
            n.cent = 8'h20;
          end else begin
            n.year = bcd_inc(cur_i.year);
          end
        end else begin
          n.month = bcd_inc(cur_i.month);
        end
      end else begin
        n.date = bcd_inc(cur_i.date);
      end
    end
  end

  assign nxt_o = n;
endmodule

// File: rtl/rtc_shadow_buf.sv
module rtc_shadow_buf
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              tick_en_i,
  input  cal_t              live_cur_i,
  input  cal_t              live_nxt_i,
  input  cal_t              buf_nxt_i,
  input  logic              wr_byte_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output cal_t              buf_o,
  output logic              commit_fire_o
);
  cal_t buf_q, staged;
  logic open_q, dirty_q;

  always_comb begin
    staged = tick_en_i ? buf_nxt_i : buf_q;
    if (wr_byte_i) begin
      case (field_e'(wr_idx_i))
        F_SEC:   staged.sec   = wr_data_i;
        F_MIN:   staged.min   = wr_data_i;
        F_HOUR:  staged.hour  = wr_data_i;
        F_DATE:  staged.date  = wr_data_i;
        F_MONTH: staged.month = wr_data_i;
        F_YEAR:  staged.year  = wr_data_i;
        F_DOW:   staged.dow   = wr_data_i[DOW_W-1:0];
        default: staged.cent  = wr_data_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= CAL_RESET;
      open_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else if (abort_i || commit_i) begin
      open_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else if (load_i) begin
      buf_q   <= tick_en_i ? live_nxt_i : live_cur_i;
      open_q  <= 1'b1;
      dirty_q <= 1'b0;
    end else if (open_q) begin
      buf_q   <= staged;
      dirty_q <= dirty_q | wr_byte_i;
    end
  end

  assign buf_o         = buf_q;
  assign commit_fire_o = commit_i && !abort_i && open_q && dirty_q;
endmodule

// File: rtl/rtc_read_latch.sv
module rtc_read_latch
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cap_i,
  input  cal_t time_i,
  output cal_t time_o
);
  cal_t hold_q;

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= CAL_RESET;
    else if (cap_i) hold_q <= time_i;
  end

  assign time_o = hold_q;
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rd_capture_i,
  input  logic              wr_load_i,
  input  logic              wr_byte_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_commit_i,
  input  logic              wr_abort_i,
  output logic [BYTE_W-1:0] rd_sec_o,
  output logic [BYTE_W-1:0] rd_min_o,
  output logic [BYTE_W-1:0] rd_hour_o,
  output logic [BYTE_W-1:0] rd_date_o,
  output logic [BYTE_W-1:0] rd_month_o,
  output logic [BYTE_W-1:0] rd_year_o,
  output logic [BYTE_W-1:0] rd_cent_o,
  output logic [DOW_W-1:0]  rd_dow_o,
  output logic              clk_fail_o
);
  cal_t live_q, live_nxt, buf_q, buf_nxt, rd_q;
  logic fail_q, tick_en, commit_fire;

  assign tick_en = tick_i && !fail_q;

  rtc_time_next u_live_next (.cur_i(live_q), .nxt_o(live_nxt));
  rtc_time_next u_buf_next  (.cur_i(buf_q),  .nxt_o(buf_nxt));

  rtc_shadow_buf u_shadow (
    .clk(clk), .rst(rst), .load_i(wr_load_i), .tick_en_i(tick_en),
    .live_cur_i(live_q), .live_nxt_i(live_nxt), .buf_nxt_i(buf_nxt),
    .wr_byte_i(wr_byte_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .commit_i(wr_commit_i), .abort_i(wr_abort_i),
    .buf_o(buf_q), .commit_fire_o(commit_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= CAL_RESET;
      fail_q <= 1'b1;
    end else if (commit_fire) begin
      live_q <= buf_q;
      fail_q <= 1'b0;
    end else if (tick_en) begin
      live_q <= live_nxt;
    end
  end

  rtc_read_latch u_rd (.clk(clk), .rst(rst), .cap_i(rd_capture_i),
                       .time_i(live_q), .time_o(rd_q));

  assign rd_sec_o   = rd_q.sec;
  assign rd_min_o   = rd_q.min;
  assign rd_hour_o  = rd_q.hour;
  assign rd_date_o  = rd_q.date;
  assign rd_month_o = rd_q.month;
  assign rd_year_o  = rd_q.year;
  assign rd_cent_o  = rd_q.cent;
  assign rd_dow_o   = rd_q.dow;
  assign clk_fail_o = fail_q;
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
  import rtc_cal_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              rd_capture_i,
  input logic              fail_q,
  input logic              commit_fire,
  input cal_t              live_q,
  input cal_t              buf_q,
  input logic [BYTE_W-1:0] rd_sec_o,
  input logic [BYTE_W-1:0] rd_min_o,
  input logic [BYTE_W-1:0] rd_hour_o,
  input logic [BYTE_W-1:0] rd_date_o,
  input logic [BYTE_W-1:0] rd_month_o,
  input logic [BYTE_W-1:0] rd_year_o,
  input logic [BYTE_W-1:0] rd_cent_o,
  input logic [DOW_W-1:0]  rd_dow_o
);
  a_r11_frozen_while_failed: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !commit_fire) |=> $stable(live_q));

  a_r9_commit_loads_buffer: assert property (@(posedge clk) disable iff (rst)
    commit_fire |=> (live_q == $past(buf_q)) && !fail_q);

  a_r1_minutes_wait_for_wrap: assert property (@(posedge clk) disable iff (rst)
    (!commit_fire && live_q.sec != 8'h59) |=> $stable(live_q.min));

  a_r7_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_capture_i |=> $stable({rd_sec_o, rd_min_o, rd_hour_o, rd_date_o,
                                rd_month_o, rd_year_o, rd_cent_o, rd_dow_o}));

  a_r10_no_change_without_cause: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !commit_fire) |=> $stable(live_q));
endmodule

bind rtc_bcd_calendar rtc_cal_checker u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .rd_capture_i(rd_capture_i),
  .fail_q(fail_q), .commit_fire(commit_fire), .live_q(live_q), .buf_q(buf_q),
  .rd_sec_o(rd_sec_o), .rd_min_o(rd_min_o), .rd_hour_o(rd_hour_o),
  .rd_date_o(rd_date_o), .rd_month_o(rd_month_o), .rd_year_o(rd_year_o),
  .rd_cent_o(rd_cent_o), .rd_dow_o(rd_dow_o)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  import rtc_cal_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, cap = 1'b0, ld = 1'b0, wb = 1'b0, cm = 1'b0, ab = 1'b0;
  logic [2:0] widx = '0;
  logic [7:0] wdat = '0;
  logic [7:0] o_sec, o_min, o_hour, o_date, o_mon, o_year, o_cent;
  logic [2:0] o_dow;
  logic       o_fail;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .rd_capture_i(cap), .wr_load_i(ld),
    .wr_byte_i(wb), .wr_idx_i(widx), .wr_data_i(wdat), .wr_commit_i(cm),
    .wr_abort_i(ab), .rd_sec_o(o_sec), .rd_min_o(o_min), .rd_hour_o(o_hour),
    .rd_date_o(o_date), .rd_month_o(o_mon), .rd_year_o(o_year),
    .rd_cent_o(o_cent), .rd_dow_o(o_dow), .clk_fail_o(o_fail)
  );

  int checks = 0, errors = 0;
  // binary reference model; hour kept as 0..23 plus a format flag
  int m_s, m_m, m_hh, m_d, m_mo, m_y, m_c, m_dw;
  bit m_h24, m_fail;

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_s++;
    if (m_s == 60) begin m_s = 0; m_m++; end
    if (m_m == 60) begin m_m = 0; m_hh++; end
    if (m_hh == 24) begin
      m_hh = 0; m_dw = (m_dw + 1) % 7; m_d++;
      if (m_d > mdays(m_mo, m_y)) begin m_d = 1; m_mo++; end
      if (m_mo == 13) begin m_mo = 1; m_y++; end
      if (m_y == 100) begin m_y = 0; m_c = 20; end
    end
  endtask

  function automatic logic [7:0] exp_hour();
    int h12;
    logic [7:0] b;
    if (m_h24) begin b = i2b(m_hh); return {2'b10, b[5:0]}; end
    h12 = (m_hh % 12 == 0) ? 12 : m_hh % 12;
    b = i2b(h12);
    return {2'b00, (m_hh >= 12), b[4:0]};
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      0: return i2b(m_s);
      1: return i2b(m_m);
      2: return exp_hour();
      3: return i2b(m_d);
      4: return i2b(m_mo);
      5: return i2b(m_y);
      6: return 8'(m_dw);
      default: return i2b(m_c);
    endcase
  endfunction

  function automatic logic [7:0] act_byte(input int i);
    case (i)
      0: return o_sec;
      1: return o_min;
      2: return o_hour;
      3: return o_date;
      4: return o_mon;
      5: return o_year;
      6: return {5'b0, o_dow};
      default: return o_cent;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic capture();
    @(negedge clk) cap = 1'b1;
    @(negedge clk) cap = 1'b0;
  endtask

  task automatic verify(input string req);
    capture();
    for (int i = 0; i < 8; i++) check(act_byte(i), exp_byte(i), req, $sformatf("field %0d", i));
    check({7'b0, o_fail}, {7'b0, m_fail}, req, "clock-fail flag");
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk) tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    if (!m_fail) repeat (n) model_tick();
  endtask

  task automatic pulse_load();   @(negedge clk) ld = 1'b1; @(negedge clk) ld = 1'b0; endtask
  task automatic pulse_commit(); @(negedge clk) cm = 1'b1; @(negedge clk) cm = 1'b0; endtask
  task automatic pulse_abort();  @(negedge clk) ab = 1'b1; @(negedge clk) ab = 1'b0; endtask

  task automatic wr(input field_e f, input logic [7:0] d);
    @(negedge clk) begin wb = 1'b1; widx = f; wdat = d; end
    @(negedge clk) wb = 1'b0;
  endtask

  task automatic program_model();
    pulse_load();
    for (int i = 0; i < 8; i++) wr(field_e'(i), exp_byte(i));
    pulse_commit();
    m_fail = 1'b0;
  endtask

  task automatic corner(input bit h24, input int hh, input int d, input int mo,
                        input int y, input int c, input int dw, input string req);
    m_s = 59; m_m = 59; m_h24 = h24; m_hh = hh; m_d = d; m_mo = mo;
    m_y = y; m_c = c; m_dw = dw;
    program_model();
    run_ticks(1);
    verify(req);
  endtask

  initial begin
    #(8 * 195000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] snap [8];
    void'($urandom(32'd2024));
    m_s = 0; m_m = 0; m_hh = 0; m_h24 = 0; m_d = 1; m_mo = 1; m_y = 0;
    m_c = 20; m_dw = 0; m_fail = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    verify("R11 reset");
    // R11: nothing counts while failed, not even an open buffer
    pulse_load();
    run_ticks(3);
    wr(F_MIN, 8'h07); m_m = 7;
    pulse_commit(); m_fail = 1'b0;
    verify("R11 first commit");

    run_ticks(5);
    verify("R1 seconds count");

    // R7: latch holds without capture
    for (int i = 0; i < 8; i++) snap[i] = exp_byte(i);
    run_ticks(10);
    for (int i = 0; i < 8; i++) check(act_byte(i), snap[i], "R7 latch hold", $sformatf("field %0d", i));
    verify("R7 recapture");

    // R10: abort, stray write, empty commit
    pulse_load(); wr(F_MIN, 8'h45); pulse_abort();
    verify("R10 abort");
    wr(F_MIN, 8'h33);
    pulse_load(); wr(F_SEC, 8'h20); m_s = 20; pulse_commit();
    verify("R10 stray write ignored");
    pulse_load(); pulse_commit();
    verify("R10 empty commit");

    // R8: buffer keeps counting; field write touches one field
    pulse_load();
    run_ticks(3);
    wr(F_HOUR, 8'h85); m_h24 = 1; m_hh = 5;
    pulse_commit();
    verify("R8 buffer counts");
    @(negedge clk) begin ld = 1'b1; tick = 1'b1; end
    @(negedge clk) begin ld = 1'b0; tick = 1'b0; end
    model_tick();
    wr(F_MIN, 8'h10); m_m = 10;
    pulse_commit();
    verify("R8 load with tick");

    // R9: tick in commit cycle is dropped
    pulse_load(); wr(F_SEC, 8'h40); m_s = 40;
    @(negedge clk) begin cm = 1'b1; tick = 1'b1; end
    @(negedge clk) begin cm = 1'b0; tick = 1'b0; end
    verify("R9 commit beats tick");
    run_ticks(1);
    verify("R9 counting resumes");

    // directed carry corners
    corner(1, 23, 31, 12, 99, 19, 6, "R5 R2 R6 century roll");
    corner(1, 23, 31, 12, 99, 20, 3, "R5 century stays 20");
    corner(1, 10, 15, 6, 40, 20, 2, "R2 hour step");
    corner(0, 11, 10, 3, 5, 20, 1, "R3 noon");
    corner(0, 23, 31, 1, 5, 20, 1, "R3 midnight");
    corner(0, 12, 10, 3, 5, 20, 1, "R3 12 to 1 PM");
    corner(0, 0, 10, 3, 5, 20, 1, "R3 12 to 1 AM");
    corner(0, 9, 10, 3, 5, 20, 1, "R3 9 to 10");
    corner(1, 23, 28, 2, 24, 20, 0, "R4 leap Feb 28");
    corner(1, 23, 29, 2, 24, 20, 0, "R4 leap Feb 29");
    corner(1, 23, 28, 2, 23, 20, 0, "R4 common Feb");
    corner(1, 23, 28, 2, 0, 20, 0, "R4 year 00 leap");
    corner(1, 23, 30, 4, 7, 20, 4, "R4 April");
    corner(1, 23, 30, 6, 7, 20, 4, "R4 June");
    corner(1, 23, 30, 9, 7, 20, 4, "R4 September");
    corner(1, 23, 30, 11, 7, 20, 4, "R4 November");
    corner(1, 23, 30, 8, 7, 20, 5, "R4 August 30");

    // random starts biased to end of day and month
    for (int it = 0; it < 24; it++) begin
      m_h24 = $urandom % 2;
      m_s = $urandom % 60;
      m_m = 40 + $urandom % 20;
      m_hh = ($urandom % 2) ? 23 : $urandom % 24;
      m_mo = 1 + $urandom % 12;
      m_y = $urandom % 100;
      m_c = 19 + $urandom % 2;
      m_dw = $urandom % 7;
      m_d = mdays(m_mo, m_y) - ($urandom % 2);
      program_model();
      run_ticks(1 + $urandom % 3000);
      verify("R1 R2 R3 R4 R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule